// File: doc/BRIEF.md
# Interlaced Video Sync Timing Generator

This block produces all line and field timing for an interlaced 625-line, 50 Hz raster from a 16 MHz clock. A cycle counter divides each 64 µs scanline into 1024 ticks. A line counter then steps through two fields of unequal length. The first field is 312 lines long and the second 313, so the vertical sync pulse lands half a line later in one field than in the other.

From these counters the block derives three sync and blanking outputs:
- an active-low horizontal sync;
- an active-low composite sync;
- a flag that marks lines carrying picture data.

It also drives a pixel-window enable, which the video datapath and RAM slot scheduler use to fetch and shift pixels. The window opens on a multiple of eight cycles so that it stays in step with the memory slots. A single-cycle interrupt marks the point where the picture has ended. A text-layout input selects 24 character rows of 8 lines, each followed by 2 blank lines, in place of the full 256-line picture.

The line length, sync width, window position, field length and picture placement are all parameters. A testbench can therefore shorten the line and still exercise both fields.

Top module: `vid_sync_gen`

## Requirements
- R1: `cyc_o` counts 0 to CYC_PER_LINE-1 (default 1023) and wraps to 0. `line_o` advances by one on each wrap.
- R2: `hsync_n_o` is low for cycles 0 to HS_LEN-1 (default 0..74) of every line and high for all other cycles.
- R3: `pix_en_o` is high only on display lines, for cycles PIX_START to PIX_START+PIX_LEN-1 (default 264..903). It is low at every other time.
- R4: `field_o` = 0 marks the short field, with lines 0..311. `field_o` = 1 marks the long field, with lines 0..312. The two fields alternate, and `field_o` toggles when the last line of a field wraps to line 0.
- R5: In field 0, vertical sync runs from line 0 cycle 0 up to and including line 2 cycle 511. In field 1, it runs from line 0 cycle 512 up to and including line 2 cycle 1023. `csync_n_o` is low whenever horizontal or vertical sync is active and high otherwise. Vertical sync has no effect on `hsync_n_o`.
- R6: With `text_mode_i` = 0, `disp_line_o` is high on lines 38 to 293 and low on every other line.
- R7: With `text_mode_i` = 1, let p = line-38. `disp_line_o` is high only when 0 <= p < 240 and p mod 10 < 8.
- R8: `irq_o` is a single-cycle pulse at line 294, cycle 0, in every field. It is low at all other times.
- R9: An asynchronous active-low reset forces cycle 0, line 0 and field 0. While reset is held, `hsync_n_o` = 0, `csync_n_o` = 0 and `irq_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| text_mode_i | input | 1 | Selects the 24-row layout with 2 blank lines per row |
| hsync_n_o | output | 1 | Horizontal sync, active low |
| csync_n_o | output | 1 | Composite sync, active low |
| pix_en_o | output | 1 | Pixel window enable |
| disp_line_o | output | 1 | Current line carries picture data |
| line_o | output | $clog2(LINES_SHORT+1) | Line within the current field |
| cyc_o | output | $clog2(CYC_PER_LINE) | Cycle within the current line |
| field_o | output | 1 | 0 = 312-line field, 1 = 313-line field |
| irq_o | output | 1 | End-of-picture pulse |

## Verification
The bench targets four corner cases.

- **Field lengths.** It probes the last cycle of each field and the first cycle of the next. A design that gave both fields the same length would drift out of interlace, and the field bit would toggle on the wrong line.
- **Vertical sync edges.** It probes the cycles on each side of the mid-line vertical sync edges in both fields. A generator that ignored the half-line offset would start or end composite sync half a line off in one of the fields.
- **Text layout.** It probes the blank-line gaps and the cut-off after row 24. An off-by-one in the row counter would show a blank line as picture, or let a 25th row through.
- **Window and interrupt.** It checks both edges of the pixel window and the interrupt cycle, which catches window bounds one cycle wide or narrow and an interrupt longer than one cycle.

// File: rtl/vsg_pkg.sv
package vsg_pkg;

    typedef enum logic {
        FLD_SHORT = 1'b0,
        FLD_LONG  = 1'b1
    } field_e;

endpackage

// File: rtl/sync_line_timer.sv
module sync_line_timer #(
    parameter int CYC_PER_LINE = 1024,
    parameter int HS_LEN       = 75,
    parameter int PIX_START    = 264,
    parameter int PIX_LEN      = 640,
    localparam int CW          = $clog2(CYC_PER_LINE)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [CW-1:0] cyc_o,
    output logic          eol_o,
    output logic          sol_o,
    output logic          upper_half_o,
    output logic          hs_act_o,
    output logic          pix_win_o
);

    localparam logic [CW-1:0] LAST_C = CW'(CYC_PER_LINE - 1);
    localparam logic [CW-1:0] HALF_C = CW'(CYC_PER_LINE / 2);
    localparam logic [CW:0]   HS_E   = (CW+1)'(HS_LEN);
    localparam logic [CW:0]   PIX_B  = (CW+1)'(PIX_START);
    localparam logic [CW:0]   PIX_E  = (CW+1)'(PIX_START + PIX_LEN);

    typedef struct packed {
        logic [CW-1:0] cyc;
        logic          hs;
        logic          pix;
    } lt_state_t;

    lt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cyc == LAST_C) begin
            st_d.cyc = '0;
        end else begin
            st_d.cyc = st_q.cyc + 1'b1;
        end
        st_d.hs  = ({1'b0, st_d.cyc} < HS_E);
        st_d.pix = ({1'b0, st_d.cyc} >= PIX_B) && ({1'b0, st_d.cyc} < PIX_E);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cyc <= '0;
            st_q.hs  <= (HS_LEN > 0);
            st_q.pix <= (PIX_START == 0) && (PIX_LEN > 0);
        end else begin
            st_q <= st_d;
        end
    end

    assign cyc_o        = st_q.cyc;
    assign eol_o        = (st_q.cyc == LAST_C);
    assign sol_o        = (st_q.cyc == '0);
    assign upper_half_o = (st_q.cyc >= HALF_C);
    assign hs_act_o     = st_q.hs;
    assign pix_win_o    = st_q.pix;

    // R1: the counter wraps to zero after the last cycle
    p_cyc_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_o == LAST_C) |=> (cyc_o == '0));

    // R2: sync ends exactly at the configured width
    p_hs_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hs_act_o) |-> ({1'b0, cyc_o} == HS_E));

    // R3: the window opens at its configured start cycle
    p_pix_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pix_win_o) |-> ({1'b0, cyc_o} == PIX_B));

endmodule

// File: rtl/sync_field_timer.sv
module sync_field_timer
    import vsg_pkg::*;
#(
    parameter int LINES_SHORT = 312,
    parameter int VS_FULL     = 2,
    parameter int PIC_FIRST   = 38,
    parameter int PIC_LINES   = 256,
    parameter int ROW_LINES   = 8,
    parameter int ROW_PITCH   = 10,
    parameter int TEXT_ROWS   = 24,
    localparam int LW         = $clog2(LINES_SHORT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          eol_i,
    input  logic          upper_half_i,
    input  logic          text_i,
    output logic [LW-1:0] line_o,
    output logic          field_o,
    output logic          vs_act_o,
    output logic          disp_o,
    output logic          pic_end_o
);

    localparam int SW = $clog2(ROW_PITCH);
    localparam int RW = $clog2(TEXT_ROWS + 1);
    localparam logic [LW-1:0] LAST_SHORT = LW'(LINES_SHORT - 1);
    localparam logic [LW-1:0] LAST_LONG  = LW'(LINES_SHORT);
    localparam logic [LW-1:0] VS_L       = LW'(VS_FULL);
    localparam logic [LW:0]   PIC_B      = (LW+1)'(PIC_FIRST);
    localparam logic [LW:0]   PIC_E      = (LW+1)'(PIC_FIRST + PIC_LINES);
    localparam logic [SW-1:0] SUB_LAST   = SW'(ROW_PITCH - 1);
    localparam logic [SW-1:0] SUB_SHOWN  = SW'(ROW_LINES);
    localparam logic [RW-1:0] ROW_MAX    = RW'(TEXT_ROWS);

    typedef struct packed {
        logic [LW-1:0] line;
        field_e        field;
        logic [SW-1:0] sub;
        logic [RW-1:0] row;
    } ft_state_t;

    ft_state_t st_d, st_q;
    logic      last_line;
    logic      in_pic;
    logic      vs_short;
    logic      vs_long;
    logic      text_show;

    always_comb begin
        st_d      = st_q;
        last_line = (st_q.field == FLD_SHORT) ? (st_q.line == LAST_SHORT)
                                              : (st_q.line == LAST_LONG);
        if (eol_i) begin
            if (last_line) begin
                st_d.line  = '0;
                st_d.field = (st_q.field == FLD_SHORT) ? FLD_LONG : FLD_SHORT;
            end else begin
                st_d.line = st_q.line + 1'b1;
            end
            if ({1'b0, st_d.line} == PIC_B) begin
                st_d.sub = '0;
                st_d.row = '0;
            end else if (st_q.sub == SUB_LAST) begin
                st_d.sub = '0;
                if (st_q.row != ROW_MAX) begin
                    st_d.row = st_q.row + 1'b1;
                end
            end else begin
                st_d.sub = st_q.sub + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.line  <= '0;
            st_q.field <= FLD_SHORT;
            st_q.sub   <= '0;
            st_q.row   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        in_pic    = ({1'b0, st_q.line} >= PIC_B) && ({1'b0, st_q.line} < PIC_E);
        vs_short  = (st_q.line < VS_L) || ((st_q.line == VS_L) && !upper_half_i);
        vs_long   = ((st_q.line == '0) && upper_half_i) ||
                    ((st_q.line != '0) && (st_q.line <= VS_L));
        text_show = (st_q.sub < SUB_SHOWN) && (st_q.row < ROW_MAX);
    end

    assign line_o    = st_q.line;
    assign field_o   = (st_q.field == FLD_LONG);
    assign vs_act_o  = (st_q.field == FLD_SHORT) ? vs_short : vs_long;
    assign disp_o    = in_pic && (!text_i || text_show);
    assign pic_end_o = ({1'b0, st_q.line} == PIC_E);

    // R4: the short field hands over to the long field
    p_short_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (eol_i && !field_o && (line_o == LAST_SHORT)) |=> (line_o == '0 && field_o));

    // R4: the long field hands back to the short field
    p_long_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (eol_i && field_o && (line_o == LAST_LONG)) |=> (line_o == '0 && !field_o));

    // R4: the short field never reaches the extra line
    p_line_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !field_o |-> (line_o < LAST_LONG));

    // R5: vertical sync only begins on line 0
    p_vs_begin_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vs_act_o) |-> (line_o == '0));

endmodule

// File: rtl/vid_sync_gen.sv
module vid_sync_gen #(
    parameter int CYC_PER_LINE = 1024,
    parameter int HS_LEN       = 75,
    parameter int PIX_START    = 264,
    parameter int PIX_LEN      = 640,
    parameter int LINES_SHORT  = 312,
    parameter int VS_FULL      = 2,
    parameter int PIC_FIRST    = 38,
    parameter int PIC_LINES    = 256,
    parameter int ROW_LINES    = 8,
    parameter int ROW_PITCH    = 10,
    parameter int TEXT_ROWS    = 24,
    localparam int CW          = $clog2(CYC_PER_LINE),
    localparam int LW          = $clog2(LINES_SHORT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          text_mode_i,
    output logic          hsync_n_o,
    output logic          csync_n_o,
    output logic          pix_en_o,
    output logic          disp_line_o,
    output logic [LW-1:0] line_o,
    output logic [CW-1:0] cyc_o,
    output logic          field_o,
    output logic          irq_o
);

    logic eol, sol, upper_half, hs_act, pix_win;
    logic vs_act, disp, pic_end;

    sync_line_timer #(
        .CYC_PER_LINE (CYC_PER_LINE),
        .HS_LEN       (HS_LEN),
        .PIX_START    (PIX_START),
        .PIX_LEN      (PIX_LEN)
    ) line_tmr_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cyc_o        (cyc_o),
        .eol_o        (eol),
        .sol_o        (sol),
        .upper_half_o (upper_half),
        .hs_act_o     (hs_act),
        .pix_win_o    (pix_win)
    );

    sync_field_timer #(
        .LINES_SHORT (LINES_SHORT),
        .VS_FULL     (VS_FULL),
        .PIC_FIRST   (PIC_FIRST),
        .PIC_LINES   (PIC_LINES),
        .ROW_LINES   (ROW_LINES),
        .ROW_PITCH   (ROW_PITCH),
        .TEXT_ROWS   (TEXT_ROWS)
    ) field_tmr_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .eol_i        (eol),
        .upper_half_i (upper_half),
        .text_i       (text_mode_i),
        .line_o       (line_o),
        .field_o      (field_o),
        .vs_act_o     (vs_act),
        .disp_o       (disp),
        .pic_end_o    (pic_end)
    );

    assign hsync_n_o   = !hs_act;
    assign csync_n_o   = !(hs_act || vs_act);
    assign disp_line_o = disp;
    assign pix_en_o    = pix_win && disp;
    assign irq_o       = pic_end && sol;

    // R3: pixels are only enabled on display lines
    p_pix_needs_disp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pix_en_o |-> disp_line_o);

    // R5: horizontal sync always shows on composite sync
    p_csync_has_hs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !hsync_n_o |-> !csync_n_o);

    // R8: the end-of-picture interrupt lasts one cycle
    p_irq_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

endmodule

// File: tb/vid_sync_gen_tb.sv
module vid_sync_gen_tb_top;

    localparam int C   = 64;
    localparam int HS  = 5;
    localparam int PS  = 16;
    localparam int PL  = 40;
    localparam int LS  = 312;
    localparam int PF  = 38;
    localparam int PN  = 256;
    localparam int FRAME = (2 * LS + 1) * C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       text_mode = 1'b0;
    logic       hsync_n, csync_n, pix_en, disp_line, field, irq;
    logic [8:0] line;
    logic [5:0] cyc;

    int checks = 0;
    int errors = 0;
    int n = 0;
    int mc = 0, ml = 0, mf = 0;
    bit done = 1'b0;
    bit model_on = 1'b0;

    always #2.5 clk = ~clk;

    vid_sync_gen #(
        .CYC_PER_LINE (C),
        .HS_LEN       (HS),
        .PIX_START    (PS),
        .PIX_LEN      (PL)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .text_mode_i (text_mode),
        .hsync_n_o   (hsync_n),
        .csync_n_o   (csync_n),
        .pix_en_o    (pix_en),
        .disp_line_o (disp_line),
        .line_o      (line),
        .cyc_o       (cyc),
        .field_o     (field),
        .irq_o       (irq)
    );

    // Probe table: {frame, field, line, cycle, text, exp{hs_n,csync_n,pix,disp,irq}}
    localparam int NV = 20;
    localparam logic [22:0] VEC [NV] = '{
        {1'b0, 1'b0, 9'd0,   6'd3,  1'b0, 5'b00000},
        {1'b0, 1'b0, 9'd2,   6'd31, 1'b0, 5'b10000},
        {1'b0, 1'b0, 9'd2,   6'd32, 1'b0, 5'b11000},
        {1'b0, 1'b0, 9'd38,  6'd15, 1'b0, 5'b11010},
        {1'b0, 1'b0, 9'd38,  6'd16, 1'b0, 5'b11110},
        {1'b0, 1'b0, 9'd38,  6'd55, 1'b0, 5'b11110},
        {1'b0, 1'b0, 9'd38,  6'd56, 1'b0, 5'b11010},
        {1'b0, 1'b0, 9'd293, 6'd20, 1'b0, 5'b11110},
        {1'b0, 1'b0, 9'd294, 6'd0,  1'b0, 5'b00001},
        {1'b0, 1'b0, 9'd311, 6'd63, 1'b0, 5'b11000},
        {1'b0, 1'b1, 9'd0,   6'd31, 1'b0, 5'b11000},
        {1'b0, 1'b1, 9'd0,   6'd32, 1'b0, 5'b10000},
        {1'b0, 1'b1, 9'd2,   6'd63, 1'b0, 5'b10000},
        {1'b0, 1'b1, 9'd3,   6'd10, 1'b0, 5'b11000},
        {1'b0, 1'b1, 9'd46,  6'd20, 1'b1, 5'b11000},
        {1'b0, 1'b1, 9'd48,  6'd20, 1'b1, 5'b11110},
        {1'b0, 1'b1, 9'd275, 6'd20, 1'b1, 5'b11110},
        {1'b0, 1'b1, 9'd278, 6'd20, 1'b1, 5'b11000},
        {1'b0, 1'b1, 9'd312, 6'd63, 1'b0, 5'b11000},
        {1'b1, 1'b0, 9'd0,   6'd0,  1'b0, 5'b00000}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            if (errors < 20)
                $display("FAIL %s %s actual=%0d expected=%0d (line %0d cyc %0d field %0d)",
                         req, what, act, exp, line, cyc, field);
        end
    endtask

    // Independent reference position
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mc <= 0; ml <= 0; mf <= 0; n <= 0;
        end else begin
            n <= n + 1;
            if (mc == C - 1) begin
                mc <= 0;
                if (ml == (mf != 0 ? LS : LS - 1)) begin
                    ml <= 0;
                    mf <= 1 - mf;
                end else begin
                    ml <= ml + 1;
                end
            end else begin
                mc <= mc + 1;
            end
        end
    end

    // Per-cycle comparison against the requirements
    always @(negedge clk) begin
        #2;
        if (rst_n && model_on) begin
            int p;
            bit e_hs, e_vs, e_disp, e_pix, e_irq;
            p      = ml - PF;
            e_hs   = (mc < HS);
            e_vs   = (mf == 0) ? ((ml < 2) || (ml == 2 && mc < C / 2))
                               : ((ml == 0 && mc >= C / 2) || ml == 1 || ml == 2);
            if (text_mode)
                e_disp = (p >= 0) && (p < 240) && ((p % 10) < 8);
            else
                e_disp = (p >= 0) && (p < PN);
            e_pix  = e_disp && (mc >= PS) && (mc < PS + PL);
            e_irq  = (ml == PF + PN) && (mc == 0);
            chk("R1", "cyc", int'(cyc), mc);
            chk("R4", "line", int'(line), ml);
            chk("R4", "field", int'(field), mf);
            chk("R2", "hsync_n", int'(hsync_n), int'(!e_hs));
            chk("R5", "csync_n", int'(csync_n), int'(!(e_hs || e_vs)));
            chk(text_mode ? "R7" : "R6", "disp", int'(disp_line), int'(e_disp));
            chk("R3", "pix_en", int'(pix_en), int'(e_pix));
            chk("R8", "irq", int'(irq), int'(e_irq));
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        chk("R9", "cyc", int'(cyc), 0);
        chk("R9", "line", int'(line), 0);
        chk("R9", "field", int'(field), 0);
        chk("R9", "hsync_n", int'(hsync_n), 0);
        chk("R9", "csync_n", int'(csync_n), 0);
        chk("R9", "irq", int'(irq), 0);
        rst_n = 1'b1;
        model_on = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [22:0] e;
            int target;
            e = VEC[i];
            text_mode = e[5];
            target = int'(e[22]) * FRAME + int'(e[21]) * LS * C
                   + int'(e[20:12]) * C + int'(e[11:6]);
            #1;
            while (n < target) @(negedge clk);
            chk("R4", "probe line", int'(line), int'(e[20:12]));
            chk("R1", "probe cyc", int'(cyc), int'(e[11:6]));
            chk("R4", "probe field", int'(field), int'(e[21]));
            chk("R2", "probe hsync_n", int'(hsync_n), int'(e[4]));
            chk("R5", "probe csync_n", int'(csync_n), int'(e[3]));
            chk("R3", "probe pix_en", int'(pix_en), int'(e[2]));
            chk(e[5] ? "R7" : "R6", "probe disp", int'(disp_line), int'(e[1]));
            chk("R8", "probe irq", int'(irq), int'(e[0]));
        end

        // R9: asynchronous reset in the middle of a field
        text_mode = 1'b0;
        repeat (70 * C + 7) @(negedge clk);
        model_on = 1'b0;
        rst_n = 1'b0;
        #1;
        chk("R9", "mid cyc", int'(cyc), 0);
        chk("R9", "mid line", int'(line), 0);
        chk("R9", "mid field", int'(field), 0);
        chk("R9", "mid hsync_n", int'(hsync_n), 0);
        chk("R9", "mid csync_n", int'(csync_n), 0);
        @(negedge clk);
        rst_n = 1'b1;
        model_on = 1'b1;
        repeat (3 * C) @(negedge clk);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule